// File: doc/BRIEF.md
# Lockable Security Control Register

This block is a small word-access register slave. It holds a 32-bit control word whose fields drive the security settings of the surrounding chip. A 5-bit lock register sits beside it. Lock bits can only be set. Each lock bit freezes one group of control fields, so that a later write leaves that group unchanged while the other bits take the written data.

A third, write-only location takes an unlock key. If the written word equals the fixed key, a privileged flag and a 3-bit enable field in the control word are forced on, and the register window stays open. Any other value forces those same bits off and closes the window. Once the window is closed, reads return zero and writes do nothing until reset.

A sticky output reports when the 3-bit enable field has ever held a value other than all-zeros or all-ones.

Top module: `secctl_regblock`

## Requirements
- R1: After reset the control word is 0x0C000000 (bits 27 and 26 set), the lock register reads 0, `win_open` is 1 and `field_incons` is 0.
- R2: A write to the lock register (offset 0x04) ORs data bits 4:0 into the lock value. Data bits 31:5 are ignored and read back as 0, and no write can clear a lock bit.
- R3: Lock bit 4 freezes control bit 12. Lock bit 3 freezes bits 11:9. Lock bit 2 freezes bit 8. Lock bit 1 freezes bit 7. Lock bit 0 freezes bits 6:0.
- R4: A write to the control word (offset 0x00) loads the written data into every bit that is not frozen. Bit 31 always reads 0, whatever is written.
- R5: Writing 0x757BDF0D to the key location (offset 0x08) sets control bit 27 and bits 11:9, even when those bits are locked, and leaves `win_open` at 1.
- R6: Writing any other value to the key location clears control bit 27 and bits 11:9, and drops `win_open` to 0.
- R7: While `win_open` is 0, every read returns 0. Writes to the control word, the lock register or the key location have no effect until reset: `ctrl_value` holds and the window does not reopen.
- R8: `field_incons` rises one cycle after control bits 11:9 hold a value other than 000 or 111, and stays at 1 until reset.
- R9: The key location and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the word access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| ctrl_value | output | 32 | Current control word, driven to the chip |
| win_open | output | 1 | High while register access is allowed |
| field_incons | output | 1 | Sticky flag for an inconsistent 3-bit enable field |

## Verification
The hardest state to reach is a locked group interacting with the key: the key must override a frozen enable field. Reaching it takes a lock write followed by a control write that tries to change that field, then the key. A second hard state comes after a wrong key. The bench then has to show that writes and even the correct key change nothing, and it can only see this through `ctrl_value` and `win_open`, because every read now returns zero. The table-driven part stacks lock bits one group at a time, so each step freezes one more group while all the others are written with opposite data.

// File: rtl/secctl_pkg.sv
// Package: shared constants for the lockable security control register.
// Assumes byte offsets on a 32-bit word bus, only word-aligned accesses.
package secctl_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int LOCK_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LOCK = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h08;

    localparam logic [DATA_W-1:0] KEY_WORD    = 32'h757B_DF0D;
    localparam logic [DATA_W-1:0] CTRL_RST    = 32'h0C00_0000;
    localparam logic [DATA_W-1:0] CTRL_WRMASK = 32'h7FFF_FFFF;
    localparam int                PRIV_BIT    = 27;
    localparam int                EN_LO       = 9;
    localparam int                EN_W        = 3;
    localparam logic [DATA_W-1:0] KEY_BITS =
        (DATA_W'(1) << PRIV_BIT) | (DATA_W'((1 << EN_W) - 1) << EN_LO);

    // Control bits frozen by each lock bit, indexed by lock bit number.
    localparam logic [DATA_W-1:0] GRP_MASK [LOCK_W] = '{
        32'h0000_007F,   // lock 0: bits 6:0
        32'h0000_0080,   // lock 1: bit 7
        32'h0000_0100,   // lock 2: bit 8
        32'h0000_0E00,   // lock 3: bits 11:9
        32'h0000_1000    // lock 4: bit 12
    };
endpackage

// File: rtl/secctl_lockreg.sv
// Module: set-only lock register.
// Each write ORs the new bits into the held value; only reset clears them.
module secctl_lockreg
    import secctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] wr_bits,
    output logic [LOCK_W-1:0] lock_q
);
    // Accumulate lock bits; a written 0 never clears a held 1.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= '0;
        else if (wr_en) lock_q <= lock_q | wr_bits;
    end

    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

// File: rtl/secctl_keygate.sv
// Module: unlock key comparator and register-window state.
// Assumes key_wr is only asserted while the window is open.
module secctl_keygate
    import secctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              key_hit,
    output logic              key_miss,
    output logic              win_open
);
    logic match;

    // Compare the written word with the fixed key.
    always_comb begin
        match    = (key_data == KEY_WORD);
        key_hit  = key_wr && match;
        key_miss = key_wr && !match;
    end

    // Window opens at reset and closes for good on a wrong key.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_open <= 1'b1;
        else if (key_miss) win_open <= 1'b0;
    end

    p_closed_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !win_open);
    p_hit_keeps_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> win_open);
endmodule

// File: rtl/secctl_ctrlreg.sv
// Module: control word with per-group freeze, key overrides and the
// sticky inconsistency flag. Assumes wr_en, key_hit, key_miss are
// mutually exclusive (one address per cycle).
module secctl_ctrlreg
    import secctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LOCK_W-1:0] lock,
    input  logic              key_hit,
    input  logic              key_miss,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              incons_q
);
    logic [DATA_W-1:0] grp_frz [LOCK_W];
    logic [DATA_W-1:0] frz;
    logic [DATA_W-1:0] ctrl_d;
    logic [EN_W-1:0]   en_fld;
    logic              en_bad;

    // One masked term per lock bit.
    for (genvar g = 0; g < LOCK_W; g++) begin : g_grp
        assign grp_frz[g] = lock[g] ? GRP_MASK[g] : '0;
    end

    // Merge the per-group terms into one frozen-bit mask.
    always_comb begin
        frz = '0;
        for (int g = 0; g < LOCK_W; g++) frz = frz | grp_frz[g];
    end

    // Next value: write merge, then key overrides.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en)    ctrl_d = ((wr_data & ~frz) | (ctrl_q & frz)) & CTRL_WRMASK;
        if (key_hit)  ctrl_d = ctrl_q | KEY_BITS;
        if (key_miss) ctrl_d = ctrl_q & ~KEY_BITS;
    end

    // Hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    // Detect a mixed enable field.
    always_comb begin
        en_fld = ctrl_q[EN_LO +: EN_W];
        en_bad = (en_fld != '0) && (en_fld != '1);
    end

    // Latch the inconsistency until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) incons_q <= 1'b0;
        else        incons_q <= incons_q | en_bad;
    end

    p_top_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[DATA_W-1] == 1'b0);
    p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_hit && !key_miss |=> (((ctrl_q ^ $past(ctrl_q)) & $past(frz)) == '0));
    p_key_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> ((ctrl_q & KEY_BITS) == KEY_BITS));
    p_miss_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_miss |=> ((ctrl_q & KEY_BITS) == '0));
    p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_bad |=> incons_q);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        incons_q |=> incons_q);
endmodule

// File: rtl/secctl_regblock.sv
// Module: top of the lockable security control register.
// Decodes word offsets, gates every access with the window state and
// drives the read mux. Reads are combinational; writes land on the edge.
module secctl_regblock
    import secctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_value,
    output logic              win_open,
    output logic              field_incons
);
    logic              wr_ok;
    logic              ctrl_wr, lock_wr, key_wr;
    logic              key_hit, key_miss;
    logic [LOCK_W-1:0] lock_q;

    // Qualify and decode write strobes.
    always_comb begin
        wr_ok   = bus_we && win_open;
        ctrl_wr = wr_ok && (bus_addr == OFS_CTRL);
        lock_wr = wr_ok && (bus_addr == OFS_LOCK);
        key_wr  = wr_ok && (bus_addr == OFS_KEY);
    end

    secctl_lockreg u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lock_wr),
        .wr_bits (bus_wdata[LOCK_W-1:0]),
        .lock_q  (lock_q)
    );

    secctl_keygate u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .key_hit  (key_hit),
        .key_miss (key_miss),
        .win_open (win_open)
    );

    secctl_ctrlreg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_data  (bus_wdata),
        .lock     (lock_q),
        .key_hit  (key_hit),
        .key_miss (key_miss),
        .ctrl_q   (ctrl_value),
        .incons_q (field_incons)
    );

    // Read mux; everything reads zero once the window has closed.
    always_comb begin
        bus_rdata = '0;
        if (win_open) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_value;
                OFS_LOCK: bus_rdata = {{(DATA_W-LOCK_W){1'b0}}, lock_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_closed_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> (bus_rdata == '0));
    p_closed_ctrl_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(ctrl_value));
    p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_KEY) |-> (bus_rdata == '0));
endmodule

// File: tb/secctl_regblock_test.sv
`timescale 1ns/1ps
module secctl_regblock_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ctrl_value;
    logic        win_open, field_incons;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    secctl_regblock uut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ctrl_value (ctrl_value), .win_open (win_open),
        .field_incons (field_incons)
    );

    // {lock bits to add, control write data, expected control word}
    localparam logic [68:0] VEC [7] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
        {5'h00, 32'h0000_0000, 32'h0000_0000},
        {5'h02, 32'h0000_00FF, 32'h0000_007F},
        {5'h01, 32'h0000_0000, 32'h0000_007F},
        {5'h10, 32'hA5A5_1FFF, 32'h25A5_0F7F},
        {5'h04, 32'h0000_0000, 32'h0000_017F},
        {5'h08, 32'hFFFF_FFFF, 32'h7FFF_E17F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1: reset state
        rd(8'h00, r); chk("R1 ctrl reset", r, 32'h0C00_0000);
        rd(8'h04, r); chk("R1 lock reset", r, 32'h0);
        chk("R1 window", {31'b0, win_open}, 32'h1);
        chk("R1 flag", {31'b0, field_incons}, 32'h0);

        // R3/R4: table walk, locks accumulate group by group
        for (int i = 0; i < 7; i++) begin
            wr(8'h04, {27'b0, VEC[i][68:64]});
            wr(8'h00, VEC[i][63:32]);
            rd(8'h00, r);
            chk($sformatf("R3/R4 vector %0d", i), r, VEC[i][31:0]);
        end
        // R2: locks held, zero write cannot clear
        wr(8'h04, 32'h0);
        rd(8'h04, r); chk("R2 lock sticky", r, 32'h0000_001F);
        chk("R8 flag stays low", {31'b0, field_incons}, 32'h0);

        // R2: upper bits ignored
        do_reset();
        wr(8'h04, 32'hFFFF_FFE0);
        rd(8'h04, r); chk("R2 upper bits ignored", r, 32'h0);
        wr(8'h00, 32'h0000_1FFF);
        rd(8'h00, r); chk("R2 no freeze from upper bits", r, 32'h0000_1FFF);

        // R5: key overrides a frozen enable field
        do_reset();
        wr(8'h04, 32'h0000_0008);
        wr(8'h00, 32'h0000_0000);
        chk("R5 pre-key ctrl", ctrl_value, 32'h0);
        wr(8'h08, 32'h757B_DF0D);
        chk("R5 key sets bits", ctrl_value, 32'h0800_0E00);
        chk("R5 window open", {31'b0, win_open}, 32'h1);
        // R9: key location and unmapped offsets read zero
        rd(8'h08, r); chk("R9 key reads zero", r, 32'h0);
        rd(8'h0C, r); chk("R9 unmapped reads zero", r, 32'h0);

        // R8: sticky inconsistency flag
        do_reset();
        wr(8'h00, 32'h0000_0200);
        @(negedge clk);
        chk("R8 flag set", {31'b0, field_incons}, 32'h1);
        wr(8'h00, 32'h0000_0000);
        @(negedge clk);
        chk("R8 flag sticky", {31'b0, field_incons}, 32'h1);

        // R6: wrong key clears bits and closes window
        wr(8'h00, 32'h0C00_0E05);
        chk("R4 write before key", ctrl_value, 32'h0C00_0E05);
        wr(8'h08, 32'h1234_5678);
        chk("R6 miss clears bits", ctrl_value, 32'h0400_0005);
        chk("R6 window closed", {31'b0, win_open}, 32'h0);

        // R7: closed window ignores everything
        rd(8'h00, r); chk("R7 ctrl reads zero", r, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R7 ctrl write ignored", ctrl_value, 32'h0400_0005);
        wr(8'h08, 32'h757B_DF0D);
        chk("R7 key ignored", {31'b0, win_open}, 32'h0);
        chk("R7 key leaves ctrl", ctrl_value, 32'h0400_0005);
        rd(8'h04, r); chk("R7 lock reads zero", r, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule